// File: doc/BRIEF.md
# Cascade Identifier Driver and Comparator

This block handles identification when several eight-level interrupt controllers are chained. Each chained device uses a 3-bit identifier, so a single master can serve up to eight slaves, for 64 levels in total. The output of each slave's interrupt request drives one request input of the master. During the two-pulse acknowledge sequence, a master drives the identifier of the slave being served onto shared cascade lines. A slave compares those lines with its own programmed identifier. The block then raises a vector-enable that lets exactly one device in the chain place the vector on the data bus.

The block takes its role from a dual-purpose pin. In non-buffered mode the pin is an active-low strap: high means master, low means slave. In buffered mode the pin becomes an active-low output that enables the external data buffers, and a configuration bit supplies the role instead. A single-device mode turns cascading off: the cascade lines stay released and the device always supplies its own vector.

A master holds an 8-bit attachment map in which bit n set means a slave hangs on input n. The master drives the cascade lines only for levels whose bit is set. For any other level the master supplies the vector itself.

Top module: `casc_id_unit`

## Requirements
- R1: During reset and after it, until an acknowledge sequence starts, cas_oe=0, cas_out=0, vec_en=0 and en_n=1.
- R2: With buf_mode=0 the role is read from sp_pin_in (1=master, 0=slave), and en_oe=0 with en_n held at 1. With buf_mode=1 the role comes from buf_master, sp_pin_in is ignored, and en_oe=1.
- R3: The block drives the cascade lines only when it is a master with single_mode=0 and the acknowledged level's bit in slave_map is 1. In that case, cas_oe is 1 and cas_out equals the acknowledged level for exactly 6 sampled cycles of a sequence whose pulses and gap each last 2 cycles: from the cycle after ack_n first falls until the cycle after ack_n rises at the end of the second pulse.
- R4: When a master acknowledges a level whose slave_map bit is 0, it keeps cas_oe=0 and raises vec_en for the 2 cycles of the second pulse.
- R5: When a master drives the cascade lines, it never raises vec_en, so only one device responds to a sequence.
- R6: A slave never drives the cascade lines. It raises vec_en during the second pulse only when the value on cas_in, registered one cycle earlier, equals own_id.
- R7: With single_mode=1 the cascade lines stay released and vec_en is 1 during the second pulse, whatever the role.
- R8: With buf_mode=1, en_n is 0 whenever rd_drive=1 or vec_en=1, and 1 otherwise.
- R9: The acknowledged level is captured when ack_n first falls. Later changes on ack_level during the same sequence do not change cas_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sp_pin_in | input | 1 | Dual-purpose pin as sensed: role strap when not buffered |
| buf_mode | input | 1 | 1 = buffered mode, so the pin becomes the buffer enable |
| buf_master | input | 1 | Role in buffered mode (1 = master) |
| single_mode | input | 1 | 1 = no cascading |
| slave_map | input | 8 | Bit n = 1: slave attached on input n |
| own_id | input | 3 | Slave's own identifier |
| ack_n | input | 1 | Acknowledge strobe, active low, two pulses per sequence |
| ack_level | input | 3 | Level granted by the priority logic |
| rd_drive | input | 1 | Device is driving the data bus for a register read |
| cas_in | input | 3 | Cascade lines as sensed |
| cas_out | output | 3 | Cascade lines as driven |
| cas_oe | output | 1 | Cascade line output enable |
| vec_en | output | 1 | This device may drive the vector |
| en_n | output | 1 | Active-low buffer enable on the dual-purpose pin |
| en_oe | output | 1 | Output enable of the dual-purpose pin |

## Verification
A sequencer stuck in the wrong phase shows at once as a cas_oe window that is not exactly six cycles long, or as vec_en outside the second pulse. A wrong role or attachment decode shows as two responders in one sequence, or as none: cas_oe and vec_en both high, or both low, within the same acknowledge. A compare or capture fault shows within one sequence: a wrong value on cas_out, or vec_en wrongly present or absent during the second pulse.

// File: rtl/casc_pkg.sv
// Package: shared types for the cascade identifier unit.
// Assumes: acknowledge sequences consist of exactly two low pulses.
package casc_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_P1   = 2'd1,
        SEQ_GAP  = 2'd2,
        SEQ_P2   = 2'd3
    } seq_t;
endpackage

// File: rtl/casc_role.sv
// Module: casc_role
// Decides master or slave role and produces the buffer-enable pin behaviour.
// Assumes: configuration inputs are static outside acknowledge sequences.
module casc_role (
    input  logic buf_mode,
    input  logic buf_master,
    input  logic sp_pin_in,
    input  logic rd_drive,
    input  logic vec_en,
    output logic is_master,
    output logic en_n,
    output logic en_oe
);
    // Role source: configuration bit when buffered, strap pin otherwise.
    always_comb begin
        is_master = buf_mode ? buf_master : sp_pin_in;
    end

    // Pin direction and active-low buffer enable while driving the data bus.
    always_comb begin
        en_oe = buf_mode;
        en_n  = ~(buf_mode & (rd_drive | vec_en));
    end
endmodule

// File: rtl/casc_seq.sv
// Module: casc_seq
// Tracks the two-pulse acknowledge sequence and latches the granted level
// on the first falling pulse.
// Assumes: ack_n is synchronous to clk.
module casc_seq #(
    parameter int ID_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ack_n,
    input  logic [ID_W-1:0]   ack_level,
    output casc_pkg::seq_t    state,
    output logic [ID_W-1:0]   level_q
);
    import casc_pkg::*;

    seq_t state_nxt;

    // Next phase of the acknowledge sequence.
    always_comb begin
        state_nxt = state;
        unique case (state)
            SEQ_IDLE: if (!ack_n) state_nxt = SEQ_P1;
            SEQ_P1:   if (ack_n)  state_nxt = SEQ_GAP;
            SEQ_GAP:  if (!ack_n) state_nxt = SEQ_P2;
            SEQ_P2:   if (ack_n)  state_nxt = SEQ_IDLE;
            default:  state_nxt = SEQ_IDLE;
        endcase
    end

    // Phase register and level capture at sequence start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SEQ_IDLE;
            level_q <= '0;
        end else begin
            state <= state_nxt;
            if (state == SEQ_IDLE && !ack_n) level_q <= ack_level;
        end
    end
endmodule

// File: rtl/casc_master_drv.sv
// Module: casc_master_drv
// Master side: looks up the attachment map for the latched level and
// drives the identifier on the cascade lines during the sequence.
// Assumes: slave identifier equals the master input it hangs on.
module casc_master_drv #(
    parameter int ID_W   = 3,
    parameter int LEVELS = 1 << ID_W
) (
    input  logic              is_master,
    input  logic              single_mode,
    input  logic [LEVELS-1:0] slave_map,
    input  casc_pkg::seq_t    state,
    input  logic [ID_W-1:0]   level_q,
    output logic              hit,
    output logic [ID_W-1:0]   cas_out,
    output logic              cas_oe
);
    import casc_pkg::*;

    logic [LEVELS-1:0] sel;

    // One decode term per level: attached and currently acknowledged.
    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        assign sel[g] = slave_map[g] & (level_q == ID_W'(g));
    end

    // Drive window from first pulse through second pulse.
    always_comb begin
        hit     = |sel;
        cas_oe  = is_master & ~single_mode & hit & (state != SEQ_IDLE);
        cas_out = cas_oe ? level_q : '0;
    end
endmodule

// File: rtl/casc_slave_cmp.sv
// Module: casc_slave_cmp
// Slave side: registers the cascade lines and compares with own identifier.
// Assumes: the master holds the lines stable before the second pulse.
module casc_slave_cmp #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] cas_in,
    input  logic [ID_W-1:0] own_id,
    output logic            match
);
    logic [ID_W-1:0] cas_q;
    logic [ID_W-1:0] eq_bits;

    // Capture register for the incoming cascade lines.
    always_ff @(posedge clk) begin
        if (!rst_n) cas_q <= '0;
        else        cas_q <= cas_in;
    end

    // Bitwise equality terms reduced to a single match.
    for (genvar b = 0; b < ID_W; b++) begin : g_bit
        assign eq_bits[b] = ~(cas_q[b] ^ own_id[b]);
    end

    always_comb match = &eq_bits;
endmodule

// File: rtl/casc_id_unit.sv
// Module: casc_id_unit (top)
// Cascade identifier driver and comparator for chained interrupt controllers.
// Assumes: ack_n, cas_in and configuration are synchronous to clk.
module casc_id_unit #(
    parameter int ID_W   = 3,
    parameter int LEVELS = 1 << ID_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sp_pin_in,
    input  logic              buf_mode,
    input  logic              buf_master,
    input  logic              single_mode,
    input  logic [LEVELS-1:0] slave_map,
    input  logic [ID_W-1:0]   own_id,
    input  logic              ack_n,
    input  logic [ID_W-1:0]   ack_level,
    input  logic              rd_drive,
    input  logic [ID_W-1:0]   cas_in,
    output logic [ID_W-1:0]   cas_out,
    output logic              cas_oe,
    output logic              vec_en,
    output logic              en_n,
    output logic              en_oe
);
    import casc_pkg::*;

    seq_t            state;
    logic [ID_W-1:0] level_q;
    logic            role_master;
    logic            hit;
    logic            match;

    casc_seq #(.ID_W(ID_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .ack_level(ack_level),
        .state(state), .level_q(level_q)
    );

    casc_master_drv #(.ID_W(ID_W), .LEVELS(LEVELS)) u_mdrv (
        .is_master(role_master), .single_mode(single_mode),
        .slave_map(slave_map), .state(state), .level_q(level_q),
        .hit(hit), .cas_out(cas_out), .cas_oe(cas_oe)
    );

    casc_slave_cmp #(.ID_W(ID_W)) u_scmp (
        .clk(clk), .rst_n(rst_n), .cas_in(cas_in), .own_id(own_id),
        .match(match)
    );

    casc_role u_role (
        .buf_mode(buf_mode), .buf_master(buf_master), .sp_pin_in(sp_pin_in),
        .rd_drive(rd_drive), .vec_en(vec_en),
        .is_master(role_master), .en_n(en_n), .en_oe(en_oe)
    );

    // Responder choice during the second pulse: exactly one device in chain.
    always_comb begin
        vec_en = (state == SEQ_P2) &
                 (single_mode | (role_master ? ~hit : match));
    end
endmodule

// File: rtl/casc_id_chk.sv
// Module: casc_id_chk
// Assertion checker bound to casc_id_unit.
module casc_id_chk #(
    parameter int ID_W = 3
) (
    input logic            clk,
    input logic            rst_n,
    input logic            buf_mode,
    input logic            buf_master,
    input logic            sp_pin_in,
    input logic            single_mode,
    input logic [ID_W-1:0] cas_in,
    input logic [ID_W-1:0] own_id,
    input logic [ID_W-1:0] cas_out,
    input logic            cas_oe,
    input logic            vec_en,
    input logic            en_n,
    input logic            en_oe,
    input logic            is_master
);
    p_pin_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !buf_mode |-> (!en_oe && en_n));

    p_drive_role_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cas_oe |-> ((buf_mode ? buf_master : sp_pin_in) && !single_mode));

    p_one_responder_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cas_oe |-> !vec_en);

    p_slave_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_en && !is_master && !single_mode) |-> ($past(cas_in) == own_id));

    p_single_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        single_mode |-> !cas_oe);

    p_buf_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_mode && vec_en) |-> !en_n);

    p_id_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_oe && $past(cas_oe)) |-> $stable(cas_out));
endmodule

bind casc_id_unit casc_id_chk #(.ID_W(ID_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .buf_master(buf_master),
    .sp_pin_in(sp_pin_in), .single_mode(single_mode), .cas_in(cas_in),
    .own_id(own_id), .cas_out(cas_out), .cas_oe(cas_oe), .vec_en(vec_en),
    .en_n(en_n), .en_oe(en_oe), .is_master(role_master)
);

// File: tb/test_casc_id_unit.sv
module test_casc_id_unit;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sp_pin_in, buf_mode, buf_master, single_mode;
    logic [7:0] slave_map;
    logic [2:0] own_id, ack_level, cas_in;
    logic       ack_n, rd_drive;
    logic [2:0] cas_out;
    logic       cas_oe, vec_en, en_n, en_oe;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    typedef struct {
        int    oe;
        int    id;
        int    vec;
        int    en;
        string req;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    casc_id_unit i_casc_id_unit (
        .clk(clk), .rst_n(rst_n), .sp_pin_in(sp_pin_in), .buf_mode(buf_mode),
        .buf_master(buf_master), .single_mode(single_mode),
        .slave_map(slave_map), .own_id(own_id), .ack_n(ack_n),
        .ack_level(ack_level), .rd_drive(rd_drive), .cas_in(cas_in),
        .cas_out(cas_out), .cas_oe(cas_oe), .vec_en(vec_en), .en_n(en_n),
        .en_oe(en_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #2;
    endtask

    // Monitor state: one window per acknowledge sequence.
    bit in_win = 0;
    bit prev_ack = 1;
    int falls, hi_cnt, oe_c, vec_c, en_c, bad_id, last_id;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (!in_win && !ack_n) begin
                in_win = 1; falls = 1; hi_cnt = 0;
                oe_c = 0; vec_c = 0; en_c = 0; bad_id = 0; last_id = 0;
            end else if (in_win) begin
                if (prev_ack && !ack_n) falls++;
                if (ack_n) hi_cnt++; else hi_cnt = 0;
            end
            if (in_win) begin
                if (cas_oe) begin oe_c++; last_id = int'(cas_out); end
                if (vec_en) vec_c++;
                if (!en_n) en_c++;
                if (falls == 2 && hi_cnt == 2) begin
                    in_win = 0;
                    if (sb.size() == 0) begin
                        check(0, "scoreboard-empty", 0, 1);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check(oe_c == e.oe, {e.req, " cas_oe cycles"}, oe_c, e.oe);
                        if (e.oe > 0)
                            check(last_id == e.id, {e.req, " cas_out id"}, last_id, e.id);
                        check(vec_c == e.vec, {e.req, " vec_en cycles"}, vec_c, e.vec);
                        check(en_c == e.en, {e.req, " en_n low cycles"}, en_c, e.en);
                    end
                end
            end
            prev_ack = ack_n;
        end
    end

    // Driver: pushes the expectation, then runs a two-pulse acknowledge.
    task automatic run_seq(input logic [2:0] lvl, input logic [2:0] lvl_late,
                           input logic [2:0] cval, input int e_oe, input int e_id,
                           input int e_vec, input int e_en, input string req);
        exp_t e;
        e.oe = e_oe; e.id = e_id; e.vec = e_vec; e.en = e_en; e.req = req;
        sb.push_back(e);
        ack_level = lvl; ack_n = 1'b0;
        step(2);
        ack_level = lvl_late; ack_n = 1'b1; cas_in = cval;
        step(2);
        ack_n = 1'b0;
        step(2);
        ack_n = 1'b1;
        step(4);
    endtask

    task automatic set_cfg(input logic pin, input logic bm, input logic bmas,
                           input logic sgl, input logic [7:0] map, input logic [2:0] oid);
        sp_pin_in = pin; buf_mode = bm; buf_master = bmas;
        single_mode = sgl; slave_map = map; own_id = oid;
        step(1);
    endtask

    initial begin
        rst_n = 1'b0; sp_pin_in = 1'b1; buf_mode = 1'b0; buf_master = 1'b0;
        single_mode = 1'b0; slave_map = 8'h04; own_id = 3'd5;
        ack_n = 1'b1; ack_level = 3'd0; rd_drive = 1'b0; cas_in = 3'd0;
        step(3);
        // R1: outputs idle in reset
        @(negedge clk);
        check(cas_oe == 0 && vec_en == 0, "R1 reset drive", int'(cas_oe), 0);
        check(cas_out == 0 && en_n == 1, "R1 reset pins", int'(cas_out), 0);
        rst_n = 1'b1;
        step(2);
        @(negedge clk);
        check(cas_oe == 0 && vec_en == 0 && en_n == 1, "R1 after reset", int'(vec_en), 0);

        // R3 R5 R9: master, slave on level 2, level input changes mid-sequence
        run_seq(3'd2, 3'd6, 3'd0, 6, 2, 0, 0, "R3/R5/R9 master attached");
        // R4: master, unattached level
        run_seq(3'd3, 3'd3, 3'd0, 0, 0, 2, 0, "R4 master own vector");
        // R2: strap low selects slave; R6 matching id
        set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 8'h04, 3'd5);
        run_seq(3'd2, 3'd2, 3'd5, 0, 0, 2, 0, "R2/R6 slave match");
        // R6: mismatch
        run_seq(3'd2, 3'd2, 3'd4, 0, 0, 0, 0, "R6 slave mismatch");
        // R7: single mode, master, attached level still no drive
        set_cfg(1'b1, 1'b0, 1'b0, 1'b1, 8'h04, 3'd5);
        run_seq(3'd2, 3'd2, 3'd0, 0, 0, 2, 0, "R7 single mode");
        // R2 R8: buffered slave despite strap high
        set_cfg(1'b1, 1'b1, 1'b0, 1'b0, 8'hFF, 3'd5);
        @(negedge clk);
        check(en_oe == 1, "R2 buffered pin output", int'(en_oe), 1);
        run_seq(3'd7, 3'd7, 3'd5, 0, 0, 2, 2, "R2/R8 buffered slave");
        // R8: buffered master, level 7 attached
        set_cfg(1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 3'd5);
        run_seq(3'd7, 3'd0, 3'd0, 6, 7, 0, 0, "R8/R3 buffered master");
        // R8: read cycle enables buffers in buffered mode
        rd_drive = 1'b1;
        @(negedge clk);
        check(en_n == 0, "R8 read enable", int'(en_n), 0);
        rd_drive = 1'b0;
        @(negedge clk);
        check(en_n == 1, "R8 read released", int'(en_n), 1);
        // R2: non-buffered ignores read for pin
        set_cfg(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 3'd5);
        rd_drive = 1'b1;
        @(negedge clk);
        check(en_oe == 0 && en_n == 1, "R2 strap mode pin input", int'(en_n), 1);
        rd_drive = 1'b0;
        step(2);
        check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule